// File: doc/BRIEF.md
# Vertical Field Divider with Graded Lock

This block follows the separated vertical sync of a video signal and works out whether the field rate is 50 Hz or 60 Hz. A line counter advances on an enable pulse that arrives twice per line, so one count is half a line. The counter is evaluated at a grading count partway through each field. At that point the controller picks one of three acceptance behaviours. The choice comes from a saturating quality counter that records how regularly past syncs fell inside the expected window. The behaviours are tight-window with a self-generated sync (trusted), window-only (probable) and accept-anything (searching).

The controller drives a clean output vertical sync pulse that is measured in enable pulses. It returns the line counter to zero at the start of each field. It reports the field rate it has settled on. A two-bit mode input can pin the controller to one field rate or leave it free to change. The 60 Hz thresholds are parameters whose defaults are the 50 Hz ones scaled by 525/625.

Top module: `vdiv_field_ctrl`

## Requirements
- R1: Reset (rst_n low) sets line_cnt_o to 0, clears vs_o, sets f60_o to 0 (50 Hz) and sets the quality counter to 0. The first graded field therefore uses searching behaviour.
- R2: line_cnt_o rises by exactly one on each clock with hen_i high. It never changes on a clock with hen_i low. Its only other move is to 0 on an enable pulse.
- R3: From 0 up to the grading count (488 at 50 Hz, 410 at 60 Hz), a rising edge on vsync_i has no effect on the count or on vs_o.
- R4: In trusted behaviour the block raises vs_o itself when the count reaches the window start (622 / 522). A sync edge with window start < count < window end (628 / 528) ends the field: the count becomes 0 on the next enable pulse. Without such an edge the count stops at 626 / 526, and the next enable pulse takes it to 0.
- R5: In probable behaviour, a sync edge strictly inside the window starts vs_o and sets the count to 0 on the next enable pulse. An edge outside the window is ignored. With no edge in the window, the enable pulse that would reach the window end sets the count to 0 instead.
- R6: In searching behaviour, any sync edge starts vs_o and sets the count to 0 on the next enable pulse. With no edge, the count wraps to 0 in place of reaching the timeout. The timeout is 722 when lock_i is high and 628 when it is low, at 50 Hz or in auto mode. It is 606 / 528 when the block is forced to 60 Hz.
- R7: Each field is graded when it ends. An in-window sync counts the quality counter up and anything else counts it down, saturating at 0 and 7. A value of 6 or 7 selects trusted, 3 to 5 selects probable, and 0 to 2 selects searching.
- R8: In trusted or probable behaviour, an in-window sync that follows one or more failed fields counts down once. The next good field counts up again. In searching behaviour there is no such penalty.
- R9: force_i = 01 forces f60_o to 1 and force_i = 10 forces it to 0, from the next clock on. Codes 00 and 11 select auto.
- R10: In auto mode, a searching-state sync edge that lies outside the current window but strictly inside the other rate's window toggles f60_o. That field is graded down.
- R11: At 60 Hz every threshold follows the 60 Hz parameters: grade 410, window 522..528, trusted stop 526, forced locked timeout 606.
- R12: vs_o stays high for exactly 6 enable pulses after it starts. f60_o = 1 means 60 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hen_i | input | 1 | Enable pulse, twice per line |
| vsync_i | input | 1 | Separated vertical sync (rising edge used) |
| lock_i | input | 1 | Horizontal phase loop locked |
| force_i | input | 2 | 00/11 auto, 01 force 60 Hz, 10 force 50 Hz |
| vs_o | output | 1 | Generated vertical sync pulse |
| f60_o | output | 1 | Field rate: 1 = 60 Hz, 0 = 50 Hz |
| line_cnt_o | output | 10 | Half-line count within the field |

## Verification
The hardest states to reach are the trusted state and the penalty path. Both can only be reached through a history of whole fields. The bench replays a scripted sequence of fields, each described by a sync position, the lock level and the mode. It first climbs the quality counter through six good fields, then drops it with a missing sync, and then sends a good sync so that it is scored as bad. Each field's length and the count at which vs_o first rises reveal which behaviour was active. A later part of the script moves the rate to 60 Hz and back under forced modes, so the 60 Hz thresholds and the auto-mode toggling are also observed.

// File: rtl/vdiv_field_ctrl.sv
module vdiv_field_ctrl #(
  parameter int CW     = 10,
  parameter int VS_LEN = 6,
  parameter int NC_MAX = 7,
  parameter int NC_TOP = 6,
  parameter int NC_MID = 3,
  parameter int G50    = 488,
  parameter int WL50   = 622,
  parameter int E50    = 626,
  parameter int WH50   = 628,
  parameter int TO50   = 722,
  parameter int G60    = (G50  * 525 + 312) / 625,
  parameter int WL60   = (WL50 * 525 + 312) / 625,
  parameter int E60    = (E50  * 525 + 312) / 625,
  parameter int WH60   = (WH50 * 525 + 312) / 625,
  parameter int TO60   = (TO50 * 525 + 312) / 625
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hen_i,
  input  logic          vsync_i,
  input  logic          lock_i,
  input  logic [1:0]    force_i,
  output logic          vs_o,
  output logic          f60_o,
  output logic [CW-1:0] line_cnt_o
);

  localparam int NW = $clog2(NC_MAX + 1);
  localparam int VW = $clog2(VS_LEN + 1);

  typedef enum logic [2:0] {S_COUNT, S_TRUST, S_WAIT, S_PROB, S_SEARCH, S_ARM} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [NW-1:0] nc;
  logic [VW-1:0] vs_left;
  logic          vs_q, bad, f60;
  logic          up, dn, vs_start, flip;

  wire vs_rise = vsync_i & ~vs_q;
  wire frc60   = (force_i == 2'b01);
  wire frc50   = (force_i == 2'b10);
  wire autom   = ~(frc60 | frc50);

  wire [CW-1:0] cnt_nxt = cnt + CW'(1);
  wire [CW-1:0] g_th  = f60 ? CW'(G60)  : CW'(G50);
  wire [CW-1:0] wl_th = f60 ? CW'(WL60) : CW'(WL50);
  wire [CW-1:0] wh_th = f60 ? CW'(WH60) : CW'(WH50);
  wire [CW-1:0] e_th  = f60 ? CW'(E60)  : CW'(E50);
  wire [CW-1:0] ol_th = f60 ? CW'(WL50) : CW'(WL60);
  wire [CW-1:0] oh_th = f60 ? CW'(WH50) : CW'(WH60);
  wire [CW-1:0] to_th = (f60 && !autom) ? (lock_i ? CW'(TO60) : CW'(WH60))
                                        : (lock_i ? CW'(TO50) : CW'(WH50));

  wire in_win = (cnt > wl_th) && (cnt < wh_th);
  wire in_oth = (cnt > ol_th) && (cnt < oh_th);
  wire penal  = bad && (st != S_SEARCH);

  st_t grade_st;
  always_comb begin
    if (nc >= NW'(NC_TOP))      grade_st = S_TRUST;
    else if (nc >= NW'(NC_MID)) grade_st = S_PROB;
    else                        grade_st = S_SEARCH;
  end

  always_comb begin
    st_n = st;
    cnt_n = cnt;
    up = 1'b0;
    dn = 1'b0;
    vs_start = 1'b0;
    flip = 1'b0;
    case (st)
      S_COUNT: begin
        if (hen_i) begin
          cnt_n = cnt_nxt;
          if (cnt_nxt == g_th) st_n = grade_st;
        end
      end
      S_TRUST: begin
        if (vs_rise && in_win) begin
          st_n = S_ARM;
          up = 1'b1;
        end else if (hen_i) begin
          cnt_n = cnt_nxt;
          if (cnt_nxt == wl_th) vs_start = 1'b1;
          if (cnt_nxt == e_th)  st_n = S_WAIT;
        end
      end
      S_WAIT: begin
        if (vs_rise && in_win) begin
          st_n = S_ARM;
          up = 1'b1;
        end else if (hen_i) begin
          cnt_n = '0;
          st_n = S_COUNT;
          dn = 1'b1;
        end
      end
      S_PROB: begin
        if (vs_rise && in_win) begin
          st_n = S_ARM;
          up = 1'b1;
          vs_start = 1'b1;
        end else if (hen_i) begin
          if (cnt_nxt == wh_th) begin
            cnt_n = '0;
            st_n = S_COUNT;
            dn = 1'b1;
          end else begin
            cnt_n = cnt_nxt;
          end
        end
      end
      S_SEARCH: begin
        if (vs_rise) begin
          st_n = S_ARM;
          vs_start = 1'b1;
          if (in_win) up = 1'b1;
          else begin
            dn = 1'b1;
            flip = autom && in_oth;
          end
        end else if (hen_i) begin
          if (cnt_nxt == to_th) begin
            cnt_n = '0;
            st_n = S_COUNT;
            dn = 1'b1;
          end else begin
            cnt_n = cnt_nxt;
          end
        end
      end
      S_ARM: begin
        if (hen_i) begin
          cnt_n = '0;
          st_n = S_COUNT;
        end
      end
      default: st_n = S_COUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_COUNT;
      cnt     <= '0;
      nc      <= '0;
      bad     <= 1'b0;
      vs_q    <= 1'b0;
      vs_left <= '0;
      f60     <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      vs_q <= vsync_i;
      if (up) begin
        bad <= 1'b0;
        if (penal) begin
          if (nc != '0) nc <= nc - NW'(1);
        end else if (nc != NW'(NC_MAX)) begin
          nc <= nc + NW'(1);
        end
      end else if (dn) begin
        bad <= 1'b1;
        if (nc != '0) nc <= nc - NW'(1);
      end
      if (vs_start)                    vs_left <= VW'(VS_LEN);
      else if (hen_i && vs_left != '0) vs_left <= vs_left - VW'(1);
      if (frc60)      f60 <= 1'b1;
      else if (frc50) f60 <= 1'b0;
      else if (flip)  f60 <= ~f60;
    end
  end

  assign vs_o       = (vs_left != '0);
  assign f60_o      = f60;
  assign line_cnt_o = cnt;

endmodule

module vdiv_field_ctrl_chk #(
  parameter int CW     = 10,
  parameter int VS_LEN = 6,
  parameter int TO50   = 722
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hen_i,
  input logic [1:0]    force_i,
  input logic          vs_o,
  input logic          f60_o,
  input logic [CW-1:0] line_cnt_o
);

  logic [7:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !vs_o) hi_cnt <= '0;
    else if (hen_i)      hi_cnt <= hi_cnt + 8'd1;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hen_i |=> $stable(line_cnt_o));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hen_i |=> (line_cnt_o == $past(line_cnt_o) + CW'(1)) || (line_cnt_o == '0)
              || (line_cnt_o == $past(line_cnt_o)));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt_o < CW'(TO50));

  // R9
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i == 2'b01) |=> f60_o);

  // R9
  force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i == 2'b10) |=> !f60_o);

  // R12
  vs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= 8'(VS_LEN));

endmodule

bind vdiv_field_ctrl vdiv_field_ctrl_chk #(.CW(CW), .VS_LEN(VS_LEN), .TO50(TO50)) u_chk (
  .clk(clk), .rst_n(rst_n), .hen_i(hen_i), .force_i(force_i),
  .vs_o(vs_o), .f60_o(f60_o), .line_cnt_o(line_cnt_o)
);

// File: tb/vdiv_field_ctrl_bench.sv
module vdiv_field_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NROW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hen = 1'b0, vsync = 1'b0, lock = 1'b1;
  logic [1:0] force_sel = 2'b00;
  logic vs, f60;
  logic [9:0] line_cnt;

  int errors = 0, checks = 0;
  int vs_at = -1;
  logic vs_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vdiv_field_ctrl u_vdiv_field_ctrl (
    .clk(clk), .rst_n(rst_n), .hen_i(hen), .vsync_i(vsync), .lock_i(lock),
    .force_i(force_sel), .vs_o(vs), .f60_o(f60), .line_cnt_o(line_cnt)
  );

  // row: {sync pos (0 = none), lock, force, expected max count, expected first vs rise count (0 = none), expected f60}
  localparam logic [33:0] TBL [NROW] = '{
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd624, 1'b1, 2'd0, 10'd624, 10'd622, 1'b0},
    {10'd0,   1'b1, 2'd0, 10'd626, 10'd622, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd622, 1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd610, 1'b1, 2'd0, 10'd626, 10'd622, 1'b0},
    {10'd600, 1'b1, 2'd0, 10'd627, 10'd0,   1'b0},
    {10'd625, 1'b1, 2'd0, 10'd625, 10'd625, 1'b0},
    {10'd0,   1'b1, 2'd0, 10'd627, 10'd0,   1'b0},
    {10'd550, 1'b1, 2'd0, 10'd550, 10'd550, 1'b0},
    {10'd0,   1'b1, 2'd0, 10'd721, 10'd0,   1'b0},
    {10'd0,   1'b0, 2'd0, 10'd627, 10'd0,   1'b0},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd525, 1'b1, 2'd0, 10'd525, 10'd525, 1'b1},
    {10'd0,   1'b1, 2'd0, 10'd526, 10'd522, 1'b1},
    {10'd0,   1'b1, 2'd0, 10'd527, 10'd0,   1'b1},
    {10'd625, 1'b1, 2'd2, 10'd625, 10'd625, 1'b0},
    {10'd525, 1'b1, 2'd2, 10'd627, 10'd0,   1'b0},
    {10'd525, 1'b1, 2'd2, 10'd525, 10'd525, 1'b0},
    {10'd0,   1'b1, 2'd1, 10'd605, 10'd0,   1'b1},
    {10'd0,   1'b0, 2'd1, 10'd527, 10'd0,   1'b1},
    {10'd0,   1'b1, 2'd0, 10'd721, 10'd0,   1'b1}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2, 16:            return "R7";
      3, 4, 5, 11, 13:        return "R5";
      6, 7, 10:               return "R4";
      8, 9, 12:               return "R8";
      14, 15:                 return "R6";
      17, 18, 19, 20, 31:     return "R10";
      26, 27, 28:             return "R9";
      default:                return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (vs && !vs_prev && vs_at < 0) vs_at = int'(line_cnt);
    vs_prev = vs;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic hen_pulse();
    hen = 1'b1;
    @(negedge clk);
    hen = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_sync();
    vsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hen = 1'b0;
    vsync = 1'b0;
    force_sel = 2'b00;
    lock = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_field(input int sp, input logic lk, input logic [1:0] fs, output int mx);
    bit sent = 0;
    lock = lk;
    force_sel = fs;
    vs_at = -1;
    mx = 0;
    for (int k = 0; k < 1000; k++) begin
      if (sp != 0 && !sent && int'(line_cnt) == sp) begin
        send_sync();
        sent = 1;
      end
      hen_pulse();
      if (line_cnt == '0) break;
      mx = int'(line_cnt);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int mx, hi;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(line_cnt == 0, "R1", "reset count", line_cnt, 0);
    chk(vs == 0, "R1", "reset vs", vs, 0);
    chk(f60 == 0, "R1", "reset rate", f60, 0);

    // R2 counting only on enable pulses
    repeat (3) hen_pulse();
    chk(line_cnt == 3, "R2", "three pulses", line_cnt, 3);
    repeat (4) @(negedge clk);
    chk(line_cnt == 3, "R2", "hold without pulse", line_cnt, 3);

    // R3 sync before grading count ignored
    while (line_cnt != 10'd100) hen_pulse();
    send_sync();
    chk(vs == 0, "R3", "vs after early sync", vs, 0);
    hen_pulse();
    chk(line_cnt == 101, "R3", "count after early sync", line_cnt, 101);

    // R6 searching accepts sync, R12 pulse length
    while (line_cnt != 10'd625) hen_pulse();
    send_sync();
    chk(vs == 1, "R12", "vs starts on sync", vs, 1);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      if (vs) hi++;
      hen_pulse();
      if (k == 0) chk(line_cnt == 0, "R6", "count cleared after sync", line_cnt, 0);
    end
    chk(hi == 6, "R12", "vs length in pulses", hi, 6);

    // R1 reset in mid field
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_cnt == 0, "R1", "mid-field reset", line_cnt, 0);

    do_reset();
    for (int i = 0; i < NROW; i++) begin
      run_field(int'(TBL[i][33:24]), TBL[i][23], TBL[i][22:21], mx);
      chk(mx == int'(TBL[i][20:11]), req_of(i), $sformatf("row %0d field end", i), mx, int'(TBL[i][20:11]));
      chk(vs_at == (TBL[i][10:1] == 0 ? -1 : int'(TBL[i][10:1])), req_of(i),
          $sformatf("row %0d vs rise", i), vs_at, TBL[i][10:1] == 0 ? -1 : int'(TBL[i][10:1]));
      chk(f60 == TBL[i][0], req_of(i), $sformatf("row %0d rate", i), f60, TBL[i][0]);
    end

    // R9 forcing takes effect at once; auto keeps the last rate
    force_sel = 2'b10;
    @(negedge clk);
    chk(f60 == 0, "R9", "force 50", f60, 0);
    force_sel = 2'b01;
    @(negedge clk);
    chk(f60 == 1, "R9", "force 60", f60, 1);
    force_sel = 2'b11;
    repeat (3) @(negedge clk);
    chk(f60 == 1, "R10", "auto holds rate", f60, 1);

    finish_run();
  end
endmodule